// File: doc/BRIEF.md
# DMA Request Qualification and Arbiter

This block sits between the request lines of a multi-channel DMA controller and its transfer sequencer. Each cycle it works out which channels have a qualified request and, while the sequencer is idle, picks one of them. A request is qualified by the channel's enable, by an external-request mask, and by a per-channel setting that accepts burst requests only. Software requests are held as pending until they are served. The winning channel index goes to the sequencer together with a flag that says whether the service is a burst (2^R transfers) or a single transfer.

The sequencer reports the end of each service. When it also flags that the channel's whole transfer is complete, the block pulses a clear strobe for that channel's enable bit, which is kept elsewhere. A channel can be set to wait for its request: after its service ends it stays active, and arbitration stays stalled, until both of its request inputs are low. This supports requesters that run on a slow or unrelated clock.

Top module: `dma_req_arbiter`

## Requirements
- R1: During and straight after reset, grantValid, busy and enClr are 0 and no software request is pending.
- R2: A channel whose reqMask bit is 1 is never granted because of its singleReq or burstReq inputs.
- R3: A channel whose burstOnly bit is 1 is not granted on singleReq alone; its burstReq is served with grantBurst = 1.
- R4: A channel whose burstOnly bit is 0 is served on singleReq with grantBurst = 0, and on burstReq with grantBurst = 1.
- R5: A 1 on swReq[c] marks channel c pending, regardless of reqMask; it stays pending until c is granted, with grantBurst = 1. A new pulse in the grant cycle keeps it pending.
- R6: A channel whose chEnable bit is 0 is never granted; its pending software request is kept.
- R7: Among qualified requests, a channel whose highPri bit is 1 wins over every channel whose highPri bit is 0, whatever the indices.
- R8: Among qualified requests of the same priority level, the lowest channel index wins.
- R9: Arbitration happens only while busy is 0. A grant raises grantValid for exactly one cycle, in the cycle after the clock edge where it was decided, and busy from then on.
- R10: seqDone while serving ends the service; if seqLast is 1 in that cycle, enClr carries a one-hot bit for the served channel for one cycle after that edge, otherwise enClr stays 0.
- R11: If waitOnReq of the served channel is 1 when its service ends, busy stays 1 until both singleReq and burstReq of that channel are 0 (the raw inputs, mask not applied), then drops on the following edge.
- R12: If waitOnReq of the served channel is 0, busy drops on the edge where seqDone is seen, even if its request is still high, and the channel may be granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| singleReq | input | NUM_CH | Per-channel single-transfer request lines |
| burstReq | input | NUM_CH | Per-channel burst request lines |
| swReq | input | NUM_CH | Software request pulses, one bit per channel |
| chEnable | input | NUM_CH | Channel enable vector |
| reqMask | input | NUM_CH | 1 blocks the channel's external requests |
| burstOnly | input | NUM_CH | 1 makes the channel ignore single requests |
| highPri | input | NUM_CH | 1 puts the channel at the high priority level |
| waitOnReq | input | NUM_CH | 1 keeps the channel active until its requests fall |
| seqDone | input | 1 | Sequencer has finished the current service |
| seqLast | input | 1 | With seqDone: the channel's transfer is complete |
| grantValid | output | 1 | One-cycle pulse announcing a new grant |
| grantCh | output | $clog2(NUM_CH) | Index of the granted channel |
| grantBurst | output | 1 | 1 for a burst service, 0 for a single transfer |
| busy | output | 1 | A channel is being served or held active |
| enClr | output | NUM_CH | One-cycle strobe clearing a channel's enable |

## Verification
The hardest situation to reach is the wait-on-request hold that overlaps a new software pulse or a higher-priority request: arbitration must stay stalled while requests pile up, and the first grant after release must still follow the priority and index rules. The stimulus gets there with directed phases that hold seqDone low or keep a served channel's request high after its service, then a long phase of random vectors with sparse requests and random seqDone, seqLast and waitOnReq, all compared each cycle against a behavioural reference model.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_HOLD  = 2'd2
  } arbState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic grant;   // arbitration result is taken this cycle
    logic done;    // current service ends this cycle
  } arbStrobe_t;

endpackage

// File: rtl/dma_arb_pick.sv
// Lowest-index finder over a request vector.
module dma_arb_pick #(
  parameter  int NUM_CH = 8,
  localparam int IW     = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] reqVec,
  output logic              found,
  output logic [IW-1:0]     idx
);

  always_comb begin
    found = |reqVec;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (reqVec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/dma_arb_ctrl.sv
// Service state machine: idle, serving, holding for request release.
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       seqDone,
  input  logic       waitSel,
  input  logic       reqLow,
  output arbStrobe_t strb,
  output logic       busy
);

  arbState_t state, stateNxt;

  always_comb begin
    strb.grant = (state == ST_IDLE) && anyReq;
    strb.done  = (state == ST_SERVE) && seqDone;
    stateNxt   = state;
    unique case (state)
      ST_IDLE:  if (strb.grant) stateNxt = ST_SERVE;
      ST_SERVE: if (strb.done)  stateNxt = waitSel ? ST_HOLD : ST_IDLE;
      ST_HOLD:  if (reqLow)     stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state != ST_IDLE);

  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !reqLow) |=> (state == ST_HOLD)); // R11

  AST_DONE_LEAVES_SERVE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SERVE && seqDone) |=> (state != ST_SERVE)); // R12

endmodule

// File: rtl/dma_arb_datapath.sv
// Request qualification, priority selection, pending software requests,
// grant registers and enable-clear strobes.
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter  int NUM_CH = 8,
  localparam int IW     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] singleReq,
  input  logic [NUM_CH-1:0] burstReq,
  input  logic [NUM_CH-1:0] swReq,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] reqMask,
  input  logic [NUM_CH-1:0] burstOnly,
  input  logic [NUM_CH-1:0] highPri,
  input  logic [NUM_CH-1:0] waitOnReq,
  input  logic              seqLast,
  input  arbStrobe_t        strb,
  output logic              anyReq,
  output logic              waitSel,
  output logic              reqLow,
  output logic              grantValid,
  output logic [IW-1:0]     grantCh,
  output logic              grantBurst,
  output logic [NUM_CH-1:0] enClr
);

  localparam logic [NUM_CH-1:0] ONE_HOT0 = {{(NUM_CH-1){1'b0}}, 1'b1};

  logic [NUM_CH-1:0] extBurst, extReq, qualReq, hiReq, swPend, winHot;
  logic              hiFound, allFound, winBurst;
  logic [IW-1:0]     hiIdx, allIdx, winIdx;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_qual
    assign extBurst[g] = burstReq[g] & ~reqMask[g];
    assign extReq[g]   = extBurst[g] | (singleReq[g] & ~burstOnly[g] & ~reqMask[g]);
    assign qualReq[g]  = (extReq[g] | swPend[g]) & chEnable[g];
  end

  assign hiReq = qualReq & highPri;

  dma_arb_pick #(.NUM_CH(NUM_CH)) i_pickHi (
    .reqVec (hiReq),
    .found  (hiFound),
    .idx    (hiIdx)
  );

  dma_arb_pick #(.NUM_CH(NUM_CH)) i_pickAll (
    .reqVec (qualReq),
    .found  (allFound),
    .idx    (allIdx)
  );

  assign anyReq   = allFound;
  assign winIdx   = hiFound ? hiIdx : allIdx;
  assign winHot   = ONE_HOT0 << winIdx;
  assign winBurst = extBurst[winIdx] | swPend[winIdx];

  // grantCh doubles as the active-channel register
  assign waitSel = waitOnReq[grantCh];
  assign reqLow  = ~(singleReq[grantCh] | burstReq[grantCh]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantCh    <= '0;
      grantBurst <= 1'b0;
      enClr      <= '0;
      swPend     <= '0;
    end else begin
      grantValid <= strb.grant;
      if (strb.grant) begin
        grantCh    <= winIdx;
        grantBurst <= winBurst;
      end
      enClr  <= (strb.done && seqLast) ? (ONE_HOT0 << grantCh) : '0;
      swPend <= (swPend & ~(strb.grant ? winHot : '0)) | swReq;
    end
  end

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !grantValid); // R9

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $past(chEnable[winIdx])); // R6

  AST_SINGLE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantBurst) |->
      $past(singleReq[winIdx] & ~reqMask[winIdx] & ~burstOnly[winIdx])); // R3

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(enClr)); // R10

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter  int NUM_CH = 8,
  localparam int IW     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] singleReq,
  input  logic [NUM_CH-1:0] burstReq,
  input  logic [NUM_CH-1:0] swReq,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] reqMask,
  input  logic [NUM_CH-1:0] burstOnly,
  input  logic [NUM_CH-1:0] highPri,
  input  logic [NUM_CH-1:0] waitOnReq,
  input  logic              seqDone,
  input  logic              seqLast,
  output logic              grantValid,
  output logic [IW-1:0]     grantCh,
  output logic              grantBurst,
  output logic              busy,
  output logic [NUM_CH-1:0] enClr
);

  arbStrobe_t strb;
  logic       anyReq, waitSel, reqLow;

  dma_arb_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .anyReq  (anyReq),
    .seqDone (seqDone),
    .waitSel (waitSel),
    .reqLow  (reqLow),
    .strb    (strb),
    .busy    (busy)
  );

  dma_arb_datapath #(.NUM_CH(NUM_CH)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .singleReq  (singleReq),
    .burstReq   (burstReq),
    .swReq      (swReq),
    .chEnable   (chEnable),
    .reqMask    (reqMask),
    .burstOnly  (burstOnly),
    .highPri    (highPri),
    .waitOnReq  (waitOnReq),
    .seqLast    (seqLast),
    .strb       (strb),
    .anyReq     (anyReq),
    .waitSel    (waitSel),
    .reqLow     (reqLow),
    .grantValid (grantValid),
    .grantCh    (grantCh),
    .grantBurst (grantBurst),
    .enClr      (enClr)
  );

  AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> busy); // R9

endmodule

// File: tb/test_dma_req_arbiter.sv
`timescale 1ns/1ps
module test_dma_req_arbiter;

  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] singleReq = '0, burstReq = '0, swReq = '0, chEnable = '0;
  logic [NCH-1:0] reqMask = '0, burstOnly = '0, highPri = '0, waitOnReq = '0;
  logic           seqDone = 1'b0, seqLast = 1'b0;
  logic           grantValid, grantBurst, busy;
  logic [2:0]     grantCh;
  logic [NCH-1:0] enClr;

  always #2.5 clk = ~clk;

  dma_req_arbiter #(.NUM_CH(NCH)) i_dma_req_arbiter (
    .clk, .rstN, .singleReq, .burstReq, .swReq, .chEnable, .reqMask,
    .burstOnly, .highPri, .waitOnReq, .seqDone, .seqLast,
    .grantValid, .grantCh, .grantBurst, .busy, .enClr
  );

  // ---------------- reference model ----------------
  int       mState;          // 0 idle, 1 serving, 2 holding
  int       mCh;
  bit [NCH-1:0] mPend, mEnClr;
  bit       mGv, mGb;
  int       vecCnt = 0, errCnt = 0;
  string    curReq = "R1";

  always @(posedge clk) begin : model
    bit [NCH-1:0] q, eb;
    int win;
    if (!rstN) begin
      mState = 0; mCh = 0; mPend = '0; mEnClr = '0; mGv = 0; mGb = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        eb[c] = burstReq[c] && !reqMask[c];
        q[c]  = chEnable[c] && (eb[c] || mPend[c] ||
                (singleReq[c] && !burstOnly[c] && !reqMask[c]));
      end
      win = -1;
      for (int c = 0; c < NCH; c++) if (win < 0 && q[c] && highPri[c]) win = c;
      for (int c = 0; c < NCH; c++) if (win < 0 && q[c]) win = c;
      mGv = 0;
      mEnClr = '0;
      if (mState == 0) begin
        if (win >= 0) begin
          mGv = 1; mCh = win; mGb = eb[win] || mPend[win];
          mPend[win] = 0;
          mState = 1;
        end
      end else if (mState == 1) begin
        if (seqDone) begin
          if (seqLast) mEnClr[mCh] = 1;
          mState = waitOnReq[mCh] ? 2 : 0;
        end
      end else begin
        if (!singleReq[mCh] && !burstReq[mCh]) mState = 0;
      end
      mPend = mPend | swReq;
    end
  end

  task automatic chk(string what, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      chk("reset grantValid", grantValid, 0);
      chk("reset busy", busy, 0);
      chk("reset enClr", enClr, 0);
    end else begin
      chk("grantValid", grantValid, mGv);
      if (mGv) begin
        chk("grantCh", grantCh, mCh);
        chk("grantBurst", grantBurst, mGb);
      end
      chk("busy", busy, mState != 0);
      chk("enClr", enClr, mEnClr);
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errCnt++;
      $display("FAIL R9 watchdog act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    singleReq = '0; burstReq = '0; swReq = '0; reqMask = '0;
    burstOnly = '0; highPri = '0; waitOnReq = '0; seqLast = 0; seqDone = 1;
    step(4);
  endtask

  initial begin
    step(3);
    @(negedge clk); rstN = 1;        // R1: first cycles after reset also compared
    chEnable = '1; seqDone = 1;
    step(2);

    curReq = "R2";                   // masked channel ignored
    reqMask = 8'h04; singleReq = 8'h04; burstReq = 8'h04; step(6);
    reqMask = '0; step(1); quiet();

    curReq = "R3";                   // burst-only ignores single
    burstOnly = 8'h08; singleReq = 8'h08; step(6);
    burstReq = 8'h08; step(2); quiet();

    curReq = "R4";                   // single and burst on normal channel
    singleReq = 8'h02; step(2); singleReq = '0;
    burstReq = 8'h02; step(2); quiet();

    curReq = "R5";                   // software pulse, masked ext
    reqMask = 8'h20; swReq = 8'h20; step(1); swReq = '0; step(5);
    seqDone = 0; singleReq = 8'h01; step(1);
    swReq = 8'h40; step(1); swReq = '0; step(3);
    seqDone = 1; step(6); quiet();

    curReq = "R6";                   // disabled channel keeps pending
    chEnable = 8'hEF; burstReq = 8'h10; swReq = 8'h10; step(1); swReq = '0;
    step(5); burstReq = '0; chEnable = '1; step(4); quiet();

    curReq = "R7";                   // high level beats lower index
    highPri = 8'h40; singleReq = 8'h41; step(6); quiet();

    curReq = "R8";                   // lowest index within a level
    singleReq = 8'h24; step(4); highPri = 8'h24; burstReq = 8'h81; step(4); quiet();

    curReq = "R9";                   // no arbitration while busy
    seqDone = 0; burstReq = 8'hFF; step(8); seqDone = 1; step(3); quiet();

    curReq = "R10";                  // enable clear strobe
    seqDone = 0; singleReq = 8'h08; step(3); seqLast = 1; seqDone = 1; step(1);
    seqDone = 0; singleReq = '0; step(3); seqLast = 0; seqDone = 1; quiet();

    curReq = "R11";                  // hold until request falls
    waitOnReq = 8'h01; singleReq = 8'h01; burstReq = 8'h04; step(8);
    singleReq = '0; step(5); quiet();

    curReq = "R12";                  // leave active with request high
    burstReq = 8'h02; step(8); quiet();

    curReq = "R2 R3 R5 R6 R7 R8 R11 R12";
    for (int k = 0; k < 4000; k++) begin
      singleReq = $urandom & $urandom;
      burstReq  = $urandom & $urandom & $urandom;
      swReq     = (($urandom % 6) == 0) ? 8'(1 << ($urandom % 8)) : '0;
      if (($urandom % 16) == 0) begin
        chEnable  = $urandom | $urandom;
        reqMask   = $urandom & $urandom;
        burstOnly = $urandom;
        highPri   = $urandom & $urandom;
        waitOnReq = $urandom & $urandom;
      end
      seqDone = ($urandom % 3) != 0;
      seqLast = $urandom;
      step(1);
    end

    quiet();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule